// File: doc/BRIEF.md
# Automatic Head Recalibration Controller

This block returns a disk drive's read/write heads to the outermost cylinder without host involvement, as soon as the drive reports that the spindle is up to speed. It watches the drive-ready level and the home-cylinder sensor. When ready becomes active and the heads are away from home, it takes ownership of the stepping path. Each rising edge of the once-per-revolution spindle index becomes a one-clock step pulse, and the direction line points outward.

When the home sensor reports the heads at the outermost cylinder, stepping stops and a settle counter runs. Seek complete is raised only after the counter expires. The sequence runs once for each period of ready. Losing ready at any point aborts the sequence and drops every output. The host may keep ownership of stepping by holding its step-enable level active; while it does, index edges are not passed on.

Top module: `auto_recal_ctrl`

## Requirements
- R1: While reset (`rst_n` low) is applied, and in the first cycle after it, `pstep_o`, `dir_o`, `busy_o` and `seek_done_o` are all 0.
- R2: When `ready_i` is 1 and `trk0_i` is 0 at a clock edge while the block is idle, `busy_o` and `dir_o` (1 = outward, toward the home cylinder) are both 1 from the following cycle.
- R3: When `ready_i` is 1 and `trk0_i` is already 1 at that edge, no stepping takes place: `busy_o` stays 0 and `seek_done_o` is 1 from the following cycle.
- R4: While stepping, each 0-to-1 transition of `index_i` sampled with `step_en_i` at 0 produces exactly one `pstep_o` pulse, one cycle wide, in the cycle after the edge that samples the transition.
- R5: An index transition sampled while `step_en_i` is 1 produces no `pstep_o` pulse.
- R6: An `index_i` level held at 1 over several edges produces only one pulse.
- R7: At the edge that samples `trk0_i` at 1 during stepping, `dir_o` falls to 0 and step pulses stop. `busy_o` stays 1 while the settle counter runs.
- R8: `seek_done_o` rises, and `busy_o` falls, exactly `SETTLE_CYCLES` clock edges after the edge at which the home sensor ended stepping.
- R9: `seek_done_o` is never 1 while `busy_o` is 1.
- R10: An edge that samples `ready_i` at 0 clears `busy_o`, `dir_o` and `seek_done_o` in the following cycle, whatever the phase, including during stepping and during settling.
- R11: While `ready_i` stays 1 after completion, a later 0 on `trk0_i` or new index edges start no further sequence: `busy_o` stays 0 and `seek_done_o` stays 1.
- R12: A fresh assertion of `ready_i` after it was 0 starts a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ready_i | input | 1 | Spindle up to speed (1 = ready) |
| index_i | input | 1 | Spindle index level, one pulse per revolution |
| trk0_i | input | 1 | Heads at the home cylinder (1 = home) |
| step_en_i | input | 1 | Host holds stepping (1 = index edges not passed on) |
| pstep_o | output | 1 | Generated step pulse, one cycle wide |
| dir_o | output | 1 | Step direction, 1 = outward toward the home cylinder |
| busy_o | output | 1 | Recalibration in progress (stepping or settling) |
| seek_done_o | output | 1 | Seek complete after the settle delay |

## Verification
The assertions assume that all inputs are synchronous to `clk` and change only between edges. They also assume that `index_i` is low for at least one sampled edge between revolutions, because a level held high is treated as one revolution. The bench drives each input at the falling edge of the clock and places an explicit low index row between every pair of index pulses. The settle count is shortened to four cycles so that the exact rise of seek complete can be pinned to one edge.

// File: rtl/recal_pkg.sv
package recal_pkg;

    typedef enum logic [1:0] {
        RC_IDLE   = 2'd0,
        RC_STEP   = 2'd1,
        RC_SETTLE = 2'd2,
        RC_DONE   = 2'd3
    } rc_state_e;

    typedef struct packed {
        rc_state_e state;
        logic      pstep;
    } rc_regs_t;

endpackage

// File: rtl/index_edge.sv
module index_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);
    logic level_d;
    logic level_q;

    always_comb begin
        level_d = level_i;
        rise_o  = level_i & ~level_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level_d;
        end
    end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int unsigned SETTLE_CYCLES = 900000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int unsigned CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        expired_o = run_i && (cnt_q == LAST);
        if (!run_i || expired_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/auto_recal_ctrl.sv
module auto_recal_ctrl #(
    parameter int unsigned SETTLE_CYCLES = 900000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ready_i,
    input  logic index_i,
    input  logic trk0_i,
    input  logic step_en_i,
    output logic pstep_o,
    output logic dir_o,
    output logic busy_o,
    output logic seek_done_o
);
    import recal_pkg::*;

    rc_regs_t r_d;
    rc_regs_t r_q;
    logic     index_rise;
    logic     settle_run;
    logic     settle_expired;

    index_edge u_index_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (index_i),
        .rise_o  (index_rise)
    );

    assign settle_run = (r_q.state == RC_SETTLE) && ready_i;

    settle_timer #(
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_settle_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (settle_run),
        .expired_o (settle_expired)
    );

    always_comb begin
        r_d       = r_q;
        r_d.pstep = 1'b0;
        if (!ready_i) begin
            r_d.state = RC_IDLE;
        end else begin
            unique case (r_q.state)
                RC_IDLE: begin
                    r_d.state = trk0_i ? RC_DONE : RC_STEP;
                end
                RC_STEP: begin
                    if (trk0_i) begin
                        r_d.state = RC_SETTLE;
                    end else begin
                        r_d.pstep = index_rise & ~step_en_i;
                    end
                end
                RC_SETTLE: begin
                    if (settle_expired) begin
                        r_d.state = RC_DONE;
                    end
                end
                RC_DONE: begin
                    r_d.state = RC_DONE;
                end
                default: r_d.state = RC_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: RC_IDLE, pstep: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign pstep_o     = r_q.pstep;
    assign dir_o       = (r_q.state == RC_STEP);
    assign busy_o      = (r_q.state == RC_STEP) || (r_q.state == RC_SETTLE);
    assign seek_done_o = (r_q.state == RC_DONE);
endmodule

// File: rtl/auto_recal_ctrl_checker.sv
module auto_recal_ctrl_checker (
    input logic clk,
    input logic rst_n,
    input logic ready_i,
    input logic index_i,
    input logic trk0_i,
    input logic step_en_i,
    input logic pstep_o,
    input logic dir_o,
    input logic busy_o,
    input logic seek_done_o
);
    assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(seek_done_o && busy_o));

    assert_ready_loss_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |=> (!busy_o && !dir_o && !seek_done_o));

    assert_step_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pstep_o |=> !pstep_o);

    assert_step_needs_enable_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pstep_o |-> ($past(!step_en_i) && $past(index_i)));

    assert_step_outward_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pstep_o |-> dir_o);

    assert_no_retrigger_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (seek_done_o && ready_i) |=> (!busy_o && seek_done_o));

    assert_home_stops_outward_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_o && trk0_i && ready_i) |=> (!dir_o && busy_o));
endmodule

bind auto_recal_ctrl auto_recal_ctrl_checker u_chk (.*);

// File: tb/auto_recal_ctrl_bench.sv
module auto_recal_ctrl_bench;
    localparam int unsigned SETTLE = 4;
    localparam int NVEC = 22;

    // Row: {ready, index, trk0, step_en, exp_busy, exp_dir, exp_pstep, exp_done}
    localparam logic [7:0] VEC [NVEC] = '{
        8'b0000_0000, // 0  idle, not ready
        8'b1000_1100, // 1  R2 start
        8'b1100_1110, // 2  R4 pulse
        8'b1100_1100, // 3  R6 held high
        8'b1001_1100, // 4  low, host holds
        8'b1101_1100, // 5  R5 blocked
        8'b1000_1100, // 6  low
        8'b1100_1110, // 7  R4 pulse again
        8'b1010_1000, // 8  R7 home, settle starts
        8'b1110_1000, // 9  R7 no step while settling
        8'b1010_1000, // 10 settle
        8'b1010_1000, // 11 R9 still busy, not done
        8'b1010_0001, // 12 R8 done
        8'b1000_0001, // 13 R11 off home, no retrigger
        8'b1100_0001, // 14 R11 index ignored
        8'b0000_0000, // 15 R10 ready lost after done
        8'b1000_1100, // 16 R12 restart
        8'b1100_1110, // 17 R4
        8'b0000_0000, // 18 R10 abort while stepping
        8'b1010_0001, // 19 R3 already home
        8'b1110_0001, // 20 R3 no step
        8'b0010_0000  // 21 R10
    };

    logic clk = 1'b0;
    logic rst_n;
    logic ready_i, index_i, trk0_i, step_en_i;
    logic pstep_o, dir_o, busy_o, seek_done_o;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    auto_recal_ctrl #(.SETTLE_CYCLES(SETTLE)) u_auto_recal_ctrl (
        .clk(clk), .rst_n(rst_n), .ready_i(ready_i), .index_i(index_i),
        .trk0_i(trk0_i), .step_en_i(step_en_i), .pstep_o(pstep_o),
        .dir_o(dir_o), .busy_o(busy_o), .seek_done_o(seek_done_o)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {busy,dir,pstep,done} actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(input logic r, input logic i, input logic t, input logic s);
        @(negedge clk);
        ready_i = r; index_i = i; trk0_i = t; step_en_i = s;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [3:0] outs();
        return {busy_o, dir_o, pstep_o, seek_done_o};
    endfunction

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        ready_i = 1'b1; index_i = 1'b0; trk0_i = 1'b0; step_en_i = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 during reset", outs(), 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;
        ready_i = 1'b0;
        @(posedge clk);
        #1;
        check("R1 after reset", outs(), 4'b0000);

        for (int k = 0; k < NVEC; k++) begin
            drive(VEC[k][7], VEC[k][6], VEC[k][5], VEC[k][4]);
            check($sformatf("R2-table row %0d", k), outs(), VEC[k][3:0]);
        end

        // R10: abort in the middle of settling
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        check("R2 restart before settle abort", outs(), 4'b1100);
        drive(1'b1, 1'b0, 1'b1, 1'b0);
        check("R7 settle entered", outs(), 4'b1000);
        drive(1'b1, 1'b0, 1'b1, 1'b0);
        check("R9 settling", outs(), 4'b1000);
        drive(1'b0, 1'b0, 1'b1, 1'b0);
        check("R10 abort during settle", outs(), 4'b0000);
        // R12: new ready period after abort, full settle count again
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        check("R12 restart after abort", outs(), 4'b1100);
        drive(1'b1, 1'b0, 1'b1, 1'b0);
        for (int k = 1; k < SETTLE; k++) begin
            drive(1'b1, 1'b0, 1'b1, 1'b0);
            check("R8 not yet done", outs(), 4'b1000);
        end
        drive(1'b1, 1'b0, 1'b1, 1'b0);
        check("R8 done on exact edge", outs(), 4'b0001);

        // R1: reset in the middle of stepping
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        check("R2 stepping before reset", outs(), 4'b1100);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 reset mid-stepping", outs(), 4'b0000);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule